// File: doc/BRIEF.md
# Two-Lane Interleaved DDS Sample Engine

This block is a direct digital synthesis core. It runs at the core clock but supplies a DAC that is clocked at twice that rate. One phase accumulator drives two lanes. On every core cycle the lanes address two separate external waveform memories at the same moment, so one cycle yields two consecutive points of the waveform. The captured pair leaves on an even/odd output bus. A downstream 2:1 serializer sends the even word to the DAC first and the odd word second.

A mode input trades output rate for table length. In fast mode the accumulator steps by twice the tuning word and each lane reads its own 64k-entry memory. In slow mode the accumulator steps by the tuning word once. The two memories then act as one table of 128k entries, and each core cycle produces a single sample that is placed in both output slots. Memory reads are pipelined. The block registers the address and expects the data a fixed number of cycles later. It carries the lane-select and mode information alongside each read, so that every returned sample is steered by the settings that were in force when its address was issued.

Top module: `dds_dual_lane`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the phase accumulator, both memory addresses, both output words and `out_valid` to zero.
- R2: After `rst` is released, `out_valid` stays low until the read pipeline has filled. With the default read latency of 1 it first reads high after the third rising edge at which `rst` is low, that is after MEM_LAT+2 edges, and it then stays high until the next reset.
- R3: In fast mode (`slow_mode` = 0) the 32-bit accumulator advances by 2×`ftw` on each edge. One edge later `mem0_addr` equals bits 31:16 of the previous accumulator value A, and `mem1_addr` equals bits 31:16 of A+`ftw`.
- R4: In fast mode, `out_even` carries the memory-0 word for the lane-0 address and `out_odd` carries the memory-1 word for the lane-1 address of the same cycle. Both appear two edges after the addresses are issued.
- R5: In slow mode (`slow_mode` = 1) the accumulator advances by `ftw` once. A 17-bit table index is formed from accumulator bits 31:15, and both `mem0_addr` and `mem1_addr` carry index bits 15:0.
- R6: In slow mode, index bit 16 picks the source: 0 selects memory 0 and 1 selects memory 1. Both `out_even` and `out_odd` carry that same word.
- R7: A change of `ftw` or `slow_mode` takes effect at the next accumulator update. Each sample already in flight keeps the lane steering and mode with which its address was issued.
- R8: Accumulator arithmetic wraps modulo 2^32, including the lane-1 address sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| ftw | input | 32 | Frequency tuning word |
| slow_mode | input | 1 | 0: two samples per cycle from 64k tables; 1: one sample per cycle from a 128k table |
| mem0_addr | output | 16 | Registered read address of waveform memory 0 |
| mem0_rdata | input | 14 | Read data of memory 0, MEM_LAT cycles after its address |
| mem1_addr | output | 16 | Registered read address of waveform memory 1 |
| mem1_rdata | input | 14 | Read data of memory 1, MEM_LAT cycles after its address |
| out_even | output | 14 | Earlier sample of the pair, sent to the DAC first |
| out_odd | output | 14 | Later sample of the pair |
| out_valid | output | 1 | Pair on the output bus is valid |

## Verification
Three things can fall in the same cycle: a mode or tuning-word switch, the issue of a new address, and the capture of data whose address was issued under the previous setting. The stimulus flips `slow_mode` and `ftw` every one to eight cycles at random, so that reads issued under both modes are in the pipeline together. A pipeline reset is also forced in the middle of a run, which lands on top of reads still in flight. A bench model, built from the requirements, tracks each issued address with its own mode. Each output pair is judged against the memory contents for that address and mode, and `out_valid` is checked across the refill.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam int unsigned DEF_PHASE_W  = 32;
    localparam int unsigned DEF_ADDR_W   = 16;
    localparam int unsigned DEF_SAMPLE_W = 14;
    localparam int unsigned DEF_MEM_LAT  = 1;

    // Steering that travels with each read through the memory latency
    typedef struct packed {
        logic sel;    // slow mode: 1 = memory 1 supplies the sample
        logic slow;   // read was issued in slow mode
        logic vld;    // read belongs to a running stream
    } rd_ctrl_t;

endpackage

// File: rtl/dds_phase_gen.sv
module dds_phase_gen
    import dds_pkg::*;
#(
    parameter int unsigned PHASE_W = DEF_PHASE_W,
    parameter int unsigned ADDR_W  = DEF_ADDR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] ftw,
    input  logic               slow,
    output logic [ADDR_W-1:0]  addr0,
    output logic [ADDR_W-1:0]  addr1,
    output rd_ctrl_t           ctrl
);

    localparam int unsigned IDX_W   = ADDR_W + 1;
    localparam int unsigned SH_FAST = PHASE_W - ADDR_W;
    localparam int unsigned SH_SLOW = PHASE_W - IDX_W;

    typedef struct packed {
        logic [PHASE_W-1:0] acc;
        logic [ADDR_W-1:0]  a0;
        logic [ADDR_W-1:0]  a1;
        rd_ctrl_t           ctrl;
    } pg_state_t;

    pg_state_t          st_d, st_q;
    logic [PHASE_W-1:0] step_d;
    logic [IDX_W-1:0]   idx_d;

    always_comb begin
        st_d   = st_q;
        idx_d  = '0;
        step_d = slow ? ftw : (ftw << 1);
        st_d.acc       = st_q.acc + step_d;
        st_d.ctrl.vld  = 1'b1;
        st_d.ctrl.slow = slow;
        if (slow) begin
            idx_d         = IDX_W'(st_q.acc >> SH_SLOW);
            st_d.a0       = idx_d[ADDR_W-1:0];
            st_d.a1       = idx_d[ADDR_W-1:0];
            st_d.ctrl.sel = idx_d[ADDR_W];
        end else begin
            st_d.a0       = ADDR_W'(st_q.acc >> SH_FAST);
            st_d.a1       = ADDR_W'((st_q.acc + ftw) >> SH_FAST);
            st_d.ctrl.sel = 1'b0;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign addr0 = st_q.a0;
    assign addr1 = st_q.a1;
    assign ctrl  = st_q.ctrl;

    // R1: reset leaves the accumulator and the address stage empty
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (st_q.acc == '0 && st_q.a0 == '0 && st_q.a1 == '0 && !st_q.ctrl.vld));

    // R3: fast mode steps the phase by twice the tuning word
    a_r3_fast_step: assert property (@(posedge clk) disable iff (rst)
        !slow |=> (st_q.acc == $past(st_q.acc) + ($past(ftw) << 1)));

    // R5: slow mode steps the phase by the tuning word once
    a_r5_slow_step: assert property (@(posedge clk) disable iff (rst)
        slow |=> (st_q.acc == $past(st_q.acc) + $past(ftw)));

    // R5: in slow mode both memories receive the same index
    a_r5_slow_same_addr: assert property (@(posedge clk) disable iff (rst)
        st_q.ctrl.slow |-> (addr0 == addr1));

endmodule

// File: rtl/dds_sample_align.sv
module dds_sample_align
    import dds_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
    parameter int unsigned MEM_LAT  = DEF_MEM_LAT
) (
    input  logic                clk,
    input  logic                rst,
    input  rd_ctrl_t            ctrl_in,
    input  logic [SAMPLE_W-1:0] d0,
    input  logic [SAMPLE_W-1:0] d1,
    output logic [SAMPLE_W-1:0] even,
    output logic [SAMPLE_W-1:0] odd,
    output logic                valid
);

    localparam int unsigned DEPTH = (MEM_LAT < 1) ? 1 : MEM_LAT;

    typedef struct packed {
        rd_ctrl_t [DEPTH-1:0] pipe;
        logic [SAMPLE_W-1:0]  even;
        logic [SAMPLE_W-1:0]  odd;
        logic                 valid;
        logic                 slow;
    } al_state_t;

    al_state_t           st_d, st_q;
    rd_ctrl_t            head_d;
    logic [SAMPLE_W-1:0] pick_d;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = ctrl_in;
        for (int i = 1; i < int'(DEPTH); i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        head_d = st_q.pipe[DEPTH-1];
        pick_d = head_d.sel ? d1 : d0;
        if (head_d.slow) begin
            st_d.even = pick_d;
            st_d.odd  = pick_d;
        end else begin
            st_d.even = d0;
            st_d.odd  = d1;
        end
        st_d.valid = head_d.vld;
        st_d.slow  = head_d.slow;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign even  = st_q.even;
    assign odd   = st_q.odd;
    assign valid = st_q.valid;

    // R2: valid is low right after any reset edge
    a_r2_valid_low_after_reset: assert property (@(posedge clk)
        rst |=> !st_q.valid);

    // R2: once up, valid stays up until reset
    a_r2_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        st_q.valid |=> st_q.valid);

    // R6: a slow-mode sample occupies both slots
    a_r6_slow_pair_equal: assert property (@(posedge clk) disable iff (rst)
        (st_q.valid && st_q.slow) |-> (st_q.even == st_q.odd));

endmodule

// File: rtl/dds_dual_lane.sv
module dds_dual_lane
    import dds_pkg::*;
#(
    parameter int unsigned PHASE_W  = DEF_PHASE_W,
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
    parameter int unsigned MEM_LAT  = DEF_MEM_LAT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PHASE_W-1:0]  ftw,
    input  logic                slow_mode,
    output logic [ADDR_W-1:0]   mem0_addr,
    input  logic [SAMPLE_W-1:0] mem0_rdata,
    output logic [ADDR_W-1:0]   mem1_addr,
    input  logic [SAMPLE_W-1:0] mem1_rdata,
    output logic [SAMPLE_W-1:0] out_even,
    output logic [SAMPLE_W-1:0] out_odd,
    output logic                out_valid
);

    rd_ctrl_t issue_ctrl;

    dds_phase_gen #(
        .PHASE_W (PHASE_W),
        .ADDR_W  (ADDR_W)
    ) u_phase (
        .clk   (clk),
        .rst   (rst),
        .ftw   (ftw),
        .slow  (slow_mode),
        .addr0 (mem0_addr),
        .addr1 (mem1_addr),
        .ctrl  (issue_ctrl)
    );

    dds_sample_align #(
        .SAMPLE_W (SAMPLE_W),
        .MEM_LAT  (MEM_LAT)
    ) u_align (
        .clk     (clk),
        .rst     (rst),
        .ctrl_in (issue_ctrl),
        .d0      (mem0_rdata),
        .d1      (mem1_rdata),
        .even    (out_even),
        .odd     (out_odd),
        .valid   (out_valid)
    );

    // R2: no valid pair can leave while the address stage is still empty
    a_r2_no_valid_before_issue: assert property (@(posedge clk) disable iff (rst)
        !issue_ctrl.vld |=> !out_valid);

endmodule

// File: tb/dds_dual_lane_bench.sv
module dds_dual_lane_bench;

    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ftw = '0;
    logic        slow_mode = 1'b0;
    logic [15:0] mem0_addr, mem1_addr;
    logic [13:0] mem0_rdata, mem1_rdata;
    logic [13:0] out_even, out_odd;
    logic        out_valid;

    int    errors = 0;
    int    checks = 0;
    bit    done   = 1'b0;
    string tag_pre = "";

    always #(CLK_NS/2) clk = ~clk;

    dds_dual_lane u_dds_dual_lane (
        .clk        (clk),
        .rst        (rst),
        .ftw        (ftw),
        .slow_mode  (slow_mode),
        .mem0_addr  (mem0_addr),
        .mem0_rdata (mem0_rdata),
        .mem1_addr  (mem1_addr),
        .mem1_rdata (mem1_rdata),
        .out_even   (out_even),
        .out_odd    (out_odd),
        .out_valid  (out_valid)
    );

    // Distinct table contents per memory so any lane swap shows
    function automatic logic [13:0] rom0(input logic [15:0] a);
        return 14'((a * 16'd37 + 16'd5) ^ (a >> 3));
    endfunction
    function automatic logic [13:0] rom1(input logic [15:0] a);
        return 14'((a * 16'd91) ^ 16'h1555);
    endfunction

    // Memory model: one cycle of read latency
    always @(posedge clk) begin
        mem0_rdata <= rom0(mem0_addr);
        mem1_rdata <= rom1(mem1_addr);
    end

    function automatic logic [15:0] exp_a0(input logic [31:0] acc, input logic slow);
        return slow ? acc[30:15] : acc[31:16];
    endfunction
    function automatic logic [15:0] exp_a1(input logic [31:0] acc, input logic [31:0] f,
                                           input logic slow);
        logic [31:0] s;
        s = acc + f;
        return slow ? acc[30:15] : s[31:16];
    endfunction
    function automatic logic [13:0] exp_even(input logic [31:0] acc, input logic slow);
        if (slow) return acc[31] ? rom1(acc[30:15]) : rom0(acc[30:15]);
        return rom0(acc[31:16]);
    endfunction
    function automatic logic [13:0] exp_odd(input logic [31:0] acc, input logic [31:0] f,
                                            input logic slow);
        logic [31:0] s;
        s = acc + f;
        if (slow) return acc[31] ? rom1(acc[30:15]) : rom0(acc[30:15]);
        return rom1(s[31:16]);
    endfunction

    // Reference model built from the requirements
    logic [31:0] m_acc = '0;
    logic [15:0] m_a0 = '0, m_a1 = '0;
    logic        m_aslow = 1'b0;
    logic        m_rst = 1'b0;
    logic [13:0] e_even [3];
    logic [13:0] e_odd  [3];
    logic        e_v    [3];
    logic        e_slow [3];

    initial begin
        for (int i = 0; i < 3; i++) begin
            e_even[i] = '0; e_odd[i] = '0; e_v[i] = 1'b0; e_slow[i] = 1'b0;
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            m_acc <= '0; m_a0 <= '0; m_a1 <= '0; m_aslow <= 1'b0; m_rst <= 1'b1;
            for (int i = 0; i < 3; i++) begin
                e_even[i] <= '0; e_odd[i] <= '0; e_v[i] <= 1'b0; e_slow[i] <= 1'b0;
            end
        end else begin
            m_rst   <= 1'b0;
            m_a0    <= exp_a0(m_acc, slow_mode);
            m_a1    <= exp_a1(m_acc, ftw, slow_mode);
            m_aslow <= slow_mode;
            e_even[0] <= exp_even(m_acc, slow_mode);
            e_odd[0]  <= exp_odd(m_acc, ftw, slow_mode);
            e_v[0]    <= 1'b1;
            e_slow[0] <= slow_mode;
            for (int i = 1; i < 3; i++) begin
                e_even[i] <= e_even[i-1]; e_odd[i] <= e_odd[i-1];
                e_v[i] <= e_v[i-1]; e_slow[i] <= e_slow[i-1];
            end
            m_acc <= m_acc + (slow_mode ? ftw : (ftw << 1));
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Sampling away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            if (m_rst) begin
                check("R1 valid in reset", 32'(out_valid), 32'd0);
                check("R1 even in reset", 32'(out_even), 32'd0);
                check("R1 odd in reset", 32'(out_odd), 32'd0);
                check("R1 addr0 in reset", 32'(mem0_addr), 32'd0);
                check("R1 addr1 in reset", 32'(mem1_addr), 32'd0);
            end else begin
                check({tag_pre, m_aslow ? "R5 addr0" : "R3 addr0"}, 32'(mem0_addr), 32'(m_a0));
                check({tag_pre, m_aslow ? "R5 addr1" : "R3 addr1"}, 32'(mem1_addr), 32'(m_a1));
                check("R2 valid timing", 32'(out_valid), 32'(e_v[2]));
                if (e_v[2]) begin
                    check({tag_pre, e_slow[2] ? "R6 even" : "R4 even"}, 32'(out_even), 32'(e_even[2]));
                    check({tag_pre, e_slow[2] ? "R6 odd" : "R4 odd"}, 32'(out_odd), 32'(e_odd[2]));
                end
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        void'($urandom(32'd4242));
        run(3);
        rst = 1'b0;
        // static output with a zero tuning word
        tag_pre = "";
        ftw = 32'h0; slow_mode = 1'b0;
        run(10);
        // lane addresses one step apart
        ftw = 32'h0001_0000;
        run(20);
        // R8: wrap of accumulator and lane-1 sum
        tag_pre = "R8/";
        ftw = 32'hFFFF_FFFF;
        run(12);
        ftw = 32'h8000_0000;
        run(8);
        // slow mode: memory select flips every two cycles
        tag_pre = "";
        slow_mode = 1'b1; ftw = 32'h4000_0000;
        run(16);
        ftw = 32'h0012_3457;
        run(20);
        // R7: frequent tuning and mode switches with reads in flight
        tag_pre = "R7/";
        for (int k = 0; k < 300; k++) begin
            ftw = $urandom();
            slow_mode = 1'($urandom_range(0, 1));
            run(int'($urandom_range(1, 8)));
        end
        // reset in the middle of a run, then refill
        tag_pre = "";
        rst = 1'b1;
        run(2);
        rst = 1'b0;
        slow_mode = 1'b0; ftw = 32'h0003_0001;
        run(30);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

endmodule